// File: doc/BRIEF.md
# Watchdog Period Control Register with Guarded Serial Write Path

This block is a slave on a two-wire serial bus (SCL/SDA, open-drain). It holds the one-byte control register whose two period bits select the watchdog timeout. The bits are exported to the watchdog as `wd_sel_o`. Any change to the period bits has to pass a volatile two-latch enable sequence. The host first writes 02h, then 06h, then the byte that carries the new period. The change takes effect on the STOP that closes that third write. After it, the block stays busy for a programmable number of clock cycles, which stands in for the nonvolatile store.

The same slave decodes two threshold-programming commands. When the high-voltage-enable input is high, each command produces a single-cycle pulse at the closing STOP. A write-protect input freezes the period bits. A protected attempt still drops the second enable latch.

SCL and SDA are sampled on `clk` and must already be synchronous to it. The bus master must hold each SCL phase for at least two clock cycles.

Top module: `wdt_ctl_slave`

## Requirements
- R1: After reset the period bits are 11, both enable latches are 0, a register read returns 60h, SDA is not pulled, and both trip pulses are low.
- R2: The slave byte is decoded as follows. `1011_00_A_W` selects the register and `1010_0000` selects the trip commands; every other slave byte is answered with NACK. A register write is acknowledged only when the address bit A is 1 and the address byte is FFh, which selects register location 1FFh. A trip command is acknowledged only with address byte 01h or 03h.
- R3: A slave byte `1011_00x1` is acknowledged and followed by exactly one byte, sent MSB first with the layout {0, P1, P0, 0, 0, EN2, EN1, 0}. Here P1:P0 are the period bits, EN2 is the second enable latch and EN1 is the first. A read changes no state, so a read placed between unlock steps does not break the sequence.
- R4: While EN1 is 0, only data 02h is acknowledged, and it sets EN1 at the STOP. Every other data byte is answered with NACK and ignored.
- R5: While EN1 is 1 and EN2 is 0, data 06h is acknowledged and sets EN2 at the STOP, data 02h is acknowledged with no effect, and every other byte except 00h is answered with NACK and ignored. EN2 is never 1 while EN1 is 0.
- R6: While both latches are 1 and write-protect is low, data of the form `0xy0_0010` is acknowledged. At the STOP it loads xy into P1:P0, clears EN2, keeps EN1, and starts the busy interval.
- R7: While both latches are 1, data of the form `0xy0_0110` is acknowledged and changes nothing. Both latches stay 1.
- R8: While EN1 is 1, data 00h is acknowledged and clears both latches at the STOP.
- R9: A second data byte in one write transaction is answered with NACK, and the first byte's pending effect is discarded.
- R10: While write-protect is high, a `0xy0_0010` byte with both latches set is acknowledged. At the STOP it clears EN2 only, and P1:P0 stay unchanged.
- R11: For COMMIT_CYCLES clock cycles after the STOP of a period change, every slave byte is answered with NACK and SDA is never pulled. After that interval, transfers are acknowledged again.
- R12: While hv-enable is high, a trip command with data 00h is acknowledged. At the STOP, address 01h gives one cycle of `trip_raise_o` and address 03h gives one cycle of `trip_reset_o`; the two pulses are never high together. While hv-enable is low, or when the data byte is not 00h, the data byte is answered with NACK and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock, sampled on clk |
| sda_i | input | 1 | Serial data as seen on the wired bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK bits and read data zeros) |
| wp_i | input | 1 | Write protect for the period bits |
| hv_en_i | input | 1 | Enables the trip-threshold commands |
| wd_sel_o | output | 2 | Period bits P1:P0 to the watchdog |
| trip_raise_o | output | 1 | One-cycle pulse: raise trip threshold |
| trip_reset_o | output | 1 | One-cycle pulse: reset trip threshold |

## Verification
The bench builds the block with COMMIT_CYCLES = 60 and the default reset value of 11 for the period bits. The short busy window has two effects. A slave byte sent straight after a commit STOP lands inside the window, which exercises the refusal. Waiting out the window before the next step costs little, so every sweep step can start from a fresh lock state.

With that setting, the bench sweeps all 256 data bytes from the locked state. From the half-unlocked state and the armed state it covers every byte ending in binary 10, with write-protect toggled across the armed sweep. Each step is compared against an arithmetic model of the latch rules.

// File: rtl/wdt_ctl_slave.sv
module wdt_ctl_slave #(
  parameter int         COMMIT_CYCLES = 20000,
  parameter logic [1:0] WD_RESET      = 2'b11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       wp_i,
  input  logic       hv_en_i,
  output logic [1:0] wd_sel_o,
  output logic       trip_raise_o,
  output logic       trip_reset_o
);

  localparam int BW = $clog2(COMMIT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SLV, S_ADR, S_DAT, S_RD, S_SKIP} st_t;
  typedef enum logic [3:0] {OP_NONE, OP_WEL, OP_ARM, OP_CLR, OP_KEEP,
                            OP_COMMIT, OP_PROT, OP_RAISE, OP_RESET} op_t;

  st_t         st, nxt, dec_nxt;
  op_t         op, dec_op;
  logic        scl_q, sda_q, ack_q, dec_ack;
  logic        tgt_trip, a8_q, trip_hi;
  logic [3:0]  cnt;
  logic [7:0]  sr, tx;
  logic [1:0]  wd, op_wd, dec_wd;
  logic        wel, rwel, raise_q, rstp_q;
  logic [BW-1:0] bcnt;

  wire start = scl_q & scl_i & sda_q & ~sda_i;
  wire stop  = scl_q & scl_i & ~sda_q & sda_i;
  wire rise  = ~scl_q & scl_i;
  wire fall  = scl_q & ~scl_i;
  wire busy  = bcnt != '0;
  wire [7:0] reg_byte = {1'b0, wd, 2'b00, rwel, wel, 1'b0};

  assign sda_pull_o   = ack_q | (st == S_RD && !tx[7]);
  assign wd_sel_o     = wd;
  assign trip_raise_o = raise_q;
  assign trip_reset_o = rstp_q;

  always_comb begin
    dec_ack = 1'b0;
    dec_nxt = S_SKIP;
    dec_op  = OP_NONE;
    dec_wd  = wd;
    case (st)
      S_SLV: begin
        if (!busy && sr[7:4] == 4'b1011 && sr[3:2] == 2'b00) begin
          dec_ack = 1'b1;
          dec_nxt = sr[0] ? S_RD : S_ADR;
        end else if (!busy && sr == 8'b1010_0000) begin
          dec_ack = 1'b1;
          dec_nxt = S_ADR;
        end
      end
      S_ADR: begin
        if (tgt_trip ? (sr == 8'h01 || sr == 8'h03) : (a8_q && sr == 8'hFF)) begin
          dec_ack = 1'b1;
          dec_nxt = S_DAT;
        end
      end
      S_DAT: begin
        if (op == OP_NONE) begin
          if (tgt_trip) begin
            if (hv_en_i && sr == 8'h00) begin
              dec_ack = 1'b1;
              dec_op  = trip_hi ? OP_RESET : OP_RAISE;
            end
          end else if (!wel) begin
            if (sr == 8'h02) begin dec_ack = 1'b1; dec_op = OP_WEL; end
          end else if (sr == 8'h00) begin
            dec_ack = 1'b1; dec_op = OP_CLR;
          end else if (!rwel) begin
            if (sr == 8'h02)      begin dec_ack = 1'b1; dec_op = OP_KEEP; end
            else if (sr == 8'h06) begin dec_ack = 1'b1; dec_op = OP_ARM;  end
          end else if ((sr & 8'h9F) == 8'h02) begin
            dec_ack = 1'b1;
            dec_op  = wp_i ? OP_PROT : OP_COMMIT;
            dec_wd  = sr[6:5];
          end else if ((sr & 8'h9F) == 8'h06) begin
            dec_ack = 1'b1; dec_op = OP_KEEP;
          end
          if (dec_ack) dec_nxt = S_DAT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; nxt <= S_IDLE; op <= OP_NONE;
      cnt <= '0; sr <= '0; tx <= '0; ack_q <= 1'b0;
      tgt_trip <= 1'b0; a8_q <= 1'b0; trip_hi <= 1'b0; op_wd <= '0;
      wd <= WD_RESET; wel <= 1'b0; rwel <= 1'b0;
      raise_q <= 1'b0; rstp_q <= 1'b0; bcnt <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      raise_q <= 1'b0;
      rstp_q  <= 1'b0;
      if (busy) bcnt <= bcnt - 1'b1;
      if (start) begin
        st <= S_SLV; cnt <= '0; ack_q <= 1'b0; op <= OP_NONE;
      end else if (stop) begin
        st <= S_IDLE; ack_q <= 1'b0; op <= OP_NONE;
        case (op)
          OP_WEL:    wel <= 1'b1;
          OP_ARM:    rwel <= 1'b1;
          OP_CLR:    begin wel <= 1'b0; rwel <= 1'b0; end
          OP_COMMIT: begin wd <= op_wd; rwel <= 1'b0; bcnt <= BW'(COMMIT_CYCLES); end
          OP_PROT:   rwel <= 1'b0;
          OP_RAISE:  raise_q <= 1'b1;
          OP_RESET:  rstp_q <= 1'b1;
          default: ;
        endcase
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (rise && cnt < 4'd8) begin
          cnt <= cnt + 4'd1;
          if (st != S_RD) sr <= {sr[6:0], sda_i};
        end
        if (fall) begin
          if (st == S_RD) begin
            if (cnt == 4'd8)      st <= S_SKIP;
            else if (cnt != 4'd0) tx <= {tx[6:0], 1'b0};
          end else if (cnt == 4'd8) begin
            ack_q <= dec_ack;
            nxt   <= dec_nxt;
            cnt   <= 4'd9;
            if (st == S_SLV) begin tgt_trip <= ~sr[4]; a8_q <= sr[1]; end
            if (st == S_ADR) trip_hi <= sr[1];
            if (st == S_DAT) begin op <= dec_op; op_wd <= dec_wd; end
          end else if (cnt == 4'd9) begin
            ack_q <= 1'b0;
            st    <= nxt;
            cnt   <= '0;
            tx    <= reg_byte;
          end
        end
      end
    end
  end

  assert_latch_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_period_only_at_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd != $past(wd)) |-> (bcnt == BW'(COMMIT_CYCLES)));

  assert_silent_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  assert_trip_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_raise_o && trip_reset_o));

  assert_trip_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_raise_o || trip_reset_o) |=> !(trip_raise_o || trip_reset_o));

endmodule

// File: tb/wdt_ctl_slave_bench.sv
module wdt_ctl_slave_bench;
  localparam int COMMIT = 60;
  localparam int LIMIT  = 190000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0, hv = 1'b0;
  logic pull, t_raise, t_reset;
  logic [1:0] wd_sel;
  wire sda = sda_m & ~pull;

  wdt_ctl_slave #(.COMMIT_CYCLES(COMMIT), .WD_RESET(2'b11)) u_wdt_ctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_pull_o(pull),
    .wp_i(wp), .hv_en_i(hv), .wd_sel_o(wd_sel),
    .trip_raise_o(t_raise), .trip_reset_o(t_reset));

  int checks = 0, fails = 0, cyc = 0, n_raise = 0, n_reset = 0;
  logic [1:0] m_wd = 2'b11;
  logic m_wel = 1'b0, m_rwel = 1'b0;

  always @(posedge clk) begin
    if (t_raise) n_raise++;
    if (t_reset) n_reset++;
    cyc++;
    if (cyc == LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(2); scl = 1'b1; tick(2); sda_m = 1'b0; tick(2); scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(2); scl = 1'b1; tick(2); sda_m = 1'b1; tick(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(2); scl = 1'b1; tick(2); scl = 1'b0;
    end
    sda_m = 1'b1; tick(2); scl = 1'b1; tick(1); a = (sda == 1'b0); tick(1); scl = 1'b0; tick(2);
  endtask

  task automatic rbyte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(2); scl = 1'b1; tick(1); b[i] = sda; tick(1); scl = 1'b0;
    end
    tick(2); scl = 1'b1; tick(2); scl = 1'b0; tick(2);
  endtask

  task automatic reg_write(input logic [7:0] d, output logic a);
    logic a1, a2;
    bus_start; wbyte(8'hB2, a1); wbyte(8'hFF, a2); wbyte(d, a); bus_stop;
    check("R2 slave ack", a1, 1); check("R2 addr ack", a2, 1);
  endtask

  task automatic reg_read(output logic [7:0] v);
    logic a;
    bus_start; wbyte(8'hB3, a); check("R3 read ack", a, 1); rbyte(v); bus_stop;
  endtask

  task automatic model(input logic [7:0] d, output logic ea, output logic cm);
    ea = 0; cm = 0;
    if (!m_wel) begin
      if (d == 8'h02) begin ea = 1; m_wel = 1; end
    end else if (d == 8'h00) begin
      ea = 1; m_wel = 0; m_rwel = 0;
    end else if (!m_rwel) begin
      if (d == 8'h02) ea = 1;
      else if (d == 8'h06) begin ea = 1; m_rwel = 1; end
    end else if (!d[7] && d[4:0] == 5'b00010) begin
      ea = 1; m_rwel = 0;
      if (!wp) begin m_wd = d[6:5]; cm = 1; end
    end else if (!d[7] && d[4:0] == 5'b00110) ea = 1;
  endtask

  task automatic expect_state(input string req);
    logic [7:0] v;
    reg_read(v);
    check(req, v, {1'b0, m_wd, 2'b00, m_rwel, m_wel, 1'b0});
    check(req, {6'd0, wd_sel}, {6'd0, m_wd});
  endtask

  task automatic quiet(input string req, input logic [7:0] d);
    logic a, ea, cm;
    reg_write(d, a); model(d, ea, cm); check(req, a, ea);
    if (cm) tick(COMMIT + 10);
  endtask

  task automatic do_write(input string req, input logic [7:0] d);
    quiet(req, d); expect_state(req);
  endtask

  task automatic set_state(input int lvl);
    if (m_wel) quiet("R8 setup", 8'h00);
    if (lvl >= 1) quiet("R4 setup", 8'h02);
    if (lvl >= 2) quiet("R5 setup", 8'h06);
  endtask

  initial begin
    logic a, a2;
    logic [7:0] v;
    int r0, s0;
    tick(4); rst_n = 1'b1; tick(4);

    // R1 reset state
    check("R1 pull", pull, 0); check("R1 trip", {t_raise, t_reset}, 0);
    check("R1 wd_sel", wd_sel, 2'b11);
    reg_read(v); check("R1 read", v, 8'h60);

    // R2 addressing
    bus_start; wbyte(8'hC2, a); bus_stop; check("R2 foreign slave", a, 0);
    bus_start; wbyte(8'hB0, a); wbyte(8'hFF, a2); bus_stop;
    check("R2 A8=0 slave", a, 1); check("R2 A8=0 addr", a2, 0);
    bus_start; wbyte(8'hB2, a); wbyte(8'hFE, a2); bus_stop; check("R2 addr FE", a2, 0);
    bus_start; wbyte(8'hA1, a); bus_stop; check("R2 trip read", a, 0);
    bus_start; wbyte(8'hA0, a); wbyte(8'h02, a2); bus_stop; check("R2 trip addr 02", a2, 0);
    expect_state("R2 no change");

    // R4 sweep from locked state
    for (int d = 0; d < 256; d++) begin
      set_state(0); do_write("R4", 8'(d));
    end

    // R5 / R8 from half-unlocked state
    for (int k = 0; k < 64; k++) begin
      set_state(1); do_write("R5", 8'(k * 4 + 2));
    end
    set_state(1); do_write("R8 clear half", 8'h00);

    // R6 / R7 / R10 from armed state
    for (int k = 0; k < 64; k++) begin
      wp = (k % 5 == 0);
      set_state(2); do_write(wp ? "R10" : "R6_R7", 8'(k * 4 + 2));
      wp = 1'b0;
    end
    set_state(2); do_write("R8 clear armed", 8'h00);

    // R3 read between unlock steps keeps the sequence
    set_state(1); expect_state("R3 between 1");
    quiet("R3 arm", 8'h06); expect_state("R3 between 2");
    do_write("R3 commit", 8'h42);

    // R9 second data byte
    set_state(2);
    bus_start; wbyte(8'hB2, a); wbyte(8'hFF, a); wbyte(8'h22, a); wbyte(8'h22, a2); bus_stop;
    check("R9 first ack", a, 1); check("R9 second nack", a2, 0);
    expect_state("R9 discarded");

    // R11 busy window
    quiet("R11 commit", 8'h02);
    set_state(2);
    reg_write(8'h22, a); check("R11 commit ack", a, 1);
    m_rwel = 0; m_wd = 2'b01;
    bus_start; wbyte(8'hB3, a); bus_stop; check("R11 busy nack", a, 0);
    tick(COMMIT + 10);
    expect_state("R11 after busy");

    // R12 trip commands
    hv = 1'b1; r0 = n_raise; s0 = n_reset;
    bus_start; wbyte(8'hA0, a); wbyte(8'h01, a2); check("R12 addr01", a2, 1);
    wbyte(8'h00, a); bus_stop; tick(2);
    check("R12 raise ack", a, 1); check("R12 raise pulses", 8'(n_raise - r0), 1);
    check("R12 no reset", 8'(n_reset - s0), 0);
    bus_start; wbyte(8'hA0, a); wbyte(8'h03, a2); wbyte(8'h00, a); bus_stop; tick(2);
    check("R12 reset ack", a, 1); check("R12 reset pulses", 8'(n_reset - s0), 1);
    check("R12 raise stays", 8'(n_raise - r0), 1);
    bus_start; wbyte(8'hA0, a); wbyte(8'h01, a2); wbyte(8'h01, a); bus_stop; tick(2);
    check("R12 bad data nack", a, 0); check("R12 bad data no pulse", 8'(n_raise - r0), 1);
    hv = 1'b0;
    bus_start; wbyte(8'hA0, a); wbyte(8'h03, a2); wbyte(8'h00, a); bus_stop; tick(2);
    check("R12 hv low nack", a, 0); check("R12 hv low no pulse", 8'(n_reset - s0), 1);
    expect_state("R12 register untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule